// File: doc/BRIEF.md
# Synchronous Burst Memory Clock Controller

This block runs synchronous burst transfers to a PSRAM or NOR flash device over a 16-bit data path. A client hands it one burst at a time: a start address, a direction flag and a beat count. The controller then drives a memory clock divided down from the system clock. That clock toggles only while a transfer is open and rests low otherwise. It also drives the chip enable, the address-valid strobe and the write enable.

Each burst starts with one memory clock cycle in which the address-valid strobe is low. A programmable number of latency cycles follows. After that, one 16-bit beat moves on every memory clock cycle in which the device does not stall the transfer with its active-low wait input. Read beats are handed back with a one-cycle valid pulse. Write beats are pulled from the client with a one-cycle ready pulse.

When the burst ends, the chip enable is released, the memory clock stops low, and a programmable turnaround gap in system clock cycles runs before the next request is accepted. The divide ratio, latency and turnaround are captured when a request is accepted.

Top module: `sbm_ctrl`

## Requirements
- R1: After reset and whenever no burst is open, `mem_clk_o` is 0, `mem_ce_no`, `mem_adv_no` and `mem_we_no` are 1, `rd_valid_o`, `wr_ready_o` and `mem_wdata_oe_o` are 0, and `req_ready_o` is 1.
- R2: During a burst the memory clock period is r system cycles, where r is `cfg_div_i` limited to the range 2..16. The clock is low for floor(r/2) cycles and high for the remaining cycles, starting low in the first cycle after acceptance.
- R3: `mem_adv_no` is low for exactly the first memory clock cycle (r system cycles) after acceptance. `mem_addr_o` carries the accepted address and stays stable while `mem_ce_no` is low.
- R4: With latency L (`cfg_lat_i` limited to 2..17), data cycle d begins 1+L memory cycles after acceptance. The first read beat is signalled (1+L+d0)*r + floor(r/2) system cycles after acceptance, where d0 is the first data cycle without wait.
- R5: If `mem_wait_ni` is 0 at the memory clock rising edge of a data cycle, that cycle moves no beat: no read data is captured and the write word stays on `mem_wdata_o`. The burst is stretched by one memory cycle per stalled cycle.
- R6: A read of `req_len_i`+1 beats gives exactly that many single-cycle `rd_valid_o` pulses. Each pulse carries the `mem_rdata_i` value present at the rising edge of its data cycle, in order.
- R7: A write asserts `mem_we_no` low for the whole burst and gives exactly `req_len_i`+1 single-cycle `wr_ready_o` pulses. Each pulse comes in the last system cycle of a memory cycle, and the word taken is on `mem_wdata_o` (with `mem_wdata_oe_o` high) throughout the next data cycle.
- R8: In the system cycle after the last data cycle ends, `mem_ce_no` is 1 and `mem_clk_o` is 0. `req_ready_o` then stays low for exactly T cycles, where T is `cfg_turn_i` (0..15).
- R9: Changes to `cfg_div_i`, `cfg_lat_i` or `cfg_turn_i` after a request is accepted do not affect that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_div_i | input | 5 | Memory clock divide ratio (limited to 2..16) |
| cfg_lat_i | input | 5 | First-data latency in memory cycles (limited to 2..17) |
| cfg_turn_i | input | 4 | Turnaround gap in system cycles |
| req_valid_i | input | 1 | Burst request valid |
| req_ready_o | output | 1 | Controller idle and able to accept |
| req_write_i | input | 1 | 1 = write burst, 0 = read burst |
| req_addr_i | input | 26 | Burst start address |
| req_len_i | input | 8 | Beat count minus one |
| rd_valid_o | output | 1 | Read beat valid pulse |
| rd_data_o | output | 16 | Read beat data |
| wr_ready_o | output | 1 | Write beat taken pulse |
| wr_data_i | input | 16 | Write beat data |
| mem_clk_o | output | 1 | Memory clock |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_adv_no | output | 1 | Address-valid strobe, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_addr_o | output | 26 | Memory address |
| mem_wdata_o | output | 16 | Write data to memory |
| mem_wdata_oe_o | output | 1 | Write data drive enable |
| mem_rdata_i | input | 16 | Read data from memory |
| mem_wait_ni | input | 1 | Memory wait, active low |

## Verification
Odd ratios are the first target. A divider that splits an odd period the wrong way shows a high phase one cycle short or long, and it samples read data one cycle off from where the bench's memory model places it. Wait cycles are placed at the first data cycle, back to back, and in the middle of bursts. A design that still counts a stalled cycle ends the burst early, returns a stale word or moves the write pointer on, and the cycle-exact beat and end-time checks catch each case. Out-of-range ratio and latency codes, zero-length and single-beat bursts, turnaround of 0 and 15, and configuration changes in the middle of a burst cover the limits and show a latency counter that is off by one or a setting that is not held.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_LAT  = 3'd2,
    ST_DATA = 3'd3,
    ST_TURN = 3'd4
  } seq_state_e;

endpackage

// File: rtl/sbm_clkdiv.sv
module sbm_clkdiv #(
  parameter int DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             run_nxt_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             mem_clk_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] phase_q, phase_d;
  logic [DIV_W-1:0] lo_len, last_ph;
  logic             clk_q;

  assign lo_len  = ratio_i >> 1;
  assign last_ph = ratio_i - DIV_W'(1);

  // phase 0 is the first low cycle; a new burst always begins at phase 0
  always_comb begin
    if (run_i && (phase_q != last_ph)) phase_d = phase_q + DIV_W'(1);
    else                                phase_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      clk_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      clk_q   <= run_nxt_i && (phase_d >= lo_len);
    end
  end

  assign mem_clk_o = clk_q;
  assign rise_o    = run_i && (phase_q == lo_len - DIV_W'(1));
  assign fall_o    = run_i && (phase_q == last_ph);

endmodule

// File: rtl/sbm_seq.sv
module sbm_seq
  import sbm_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int LAT_W  = 5,
  parameter int TURN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              req_write_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic [TURN_W-1:0] turn_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              wait_ni,
  output logic              idle_o,
  output logic              run_o,
  output logic              run_nxt_o,
  output logic              take_o,
  output logic              load_o,
  output logic              wr_o,
  output logic              ce_no,
  output logic              adv_no,
  output logic              we_no,
  output logic              oe_o
);

  seq_state_e        state_q, state_d;
  logic [LAT_W-1:0]  lat_cnt_q;
  logic [LEN_W-1:0]  beats_q;
  logic [TURN_W-1:0] turn_cnt_q;
  logic              wr_q, acc_q, last_q;
  logic              ce_n_q, adv_n_q, we_n_q, oe_q;
  logic              lat_done, data_end;

  assign lat_done = (state_q == ST_LAT) && fall_i && (lat_cnt_q == LAT_W'(1));
  assign data_end = (state_q == ST_DATA) && fall_i && last_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_i) state_d = ST_ADDR;
      ST_ADDR: if (fall_i) state_d = ST_LAT;
      ST_LAT:  if (lat_done) state_d = ST_DATA;
      ST_DATA: if (data_end) state_d = (turn_i == '0) ? ST_IDLE : ST_TURN;
      ST_TURN: if (turn_cnt_q == TURN_W'(1)) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign take_o = (state_q == ST_DATA) && rise_i && wait_ni && !last_q;
  assign load_o = wr_q && (lat_done ||
                  ((state_q == ST_DATA) && fall_i && acc_q && !last_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      lat_cnt_q  <= '0;
      beats_q    <= '0;
      turn_cnt_q <= '0;
      wr_q       <= 1'b0;
      acc_q      <= 1'b0;
      last_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_i) begin
        wr_q    <= req_write_i;
        beats_q <= req_len_i;
        last_q  <= 1'b0;
        acc_q   <= 1'b0;
      end
      if ((state_q == ST_ADDR) && fall_i) lat_cnt_q <= lat_i;
      else if ((state_q == ST_LAT) && fall_i) lat_cnt_q <= lat_cnt_q - LAT_W'(1);
      // acc_q marks a beat that moved in the current memory cycle
      if (take_o) begin
        acc_q <= 1'b1;
        if (beats_q == '0) last_q <= 1'b1;
        else               beats_q <= beats_q - LEN_W'(1);
      end else if (fall_i) begin
        acc_q <= 1'b0;
      end
      if (data_end) turn_cnt_q <= turn_i;
      else if (state_q == ST_TURN) turn_cnt_q <= turn_cnt_q - TURN_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_q  <= 1'b1;
      adv_n_q <= 1'b1;
      we_n_q  <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      if (accept_i) begin
        ce_n_q  <= 1'b0;
        adv_n_q <= 1'b0;
        we_n_q  <= !req_write_i;
      end
      if ((state_q == ST_ADDR) && fall_i) adv_n_q <= 1'b1;
      if (lat_done && wr_q) oe_q <= 1'b1;
      if (data_end) begin
        ce_n_q <= 1'b1;
        we_n_q <= 1'b1;
        oe_q   <= 1'b0;
      end
    end
  end

  assign idle_o    = (state_q == ST_IDLE);
  assign run_o     = (state_q == ST_ADDR) || (state_q == ST_LAT) || (state_q == ST_DATA);
  assign run_nxt_o = (state_d == ST_ADDR) || (state_d == ST_LAT) || (state_d == ST_DATA);
  assign wr_o      = wr_q;
  assign ce_no     = ce_n_q;
  assign adv_no    = adv_n_q;
  assign we_no     = we_n_q;
  assign oe_o      = oe_q;

endmodule

// File: rtl/sbm_dpath.sv
module sbm_dpath #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              take_rd_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] wdata_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rd_q, wd_q;
  logic              rv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rd_q   <= '0;
      wd_q   <= '0;
      rv_q   <= 1'b0;
    end else begin
      if (accept_i)  addr_q <= addr_i;
      rv_q <= take_rd_i;
      if (take_rd_i) rd_q <= rdata_i;
      if (load_i)    wd_q <= wdata_i;
    end
  end

  assign addr_o     = addr_q;
  assign rd_valid_o = rv_q;
  assign rd_data_o  = rd_q;
  assign wdata_o    = wd_q;

endmodule

// File: rtl/sbm_ctrl.sv
module sbm_ctrl #(
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 16,
  parameter int LEN_W   = 8,
  parameter int DIV_W   = 5,
  parameter int LAT_W   = 5,
  parameter int TURN_W  = 4,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 16,
  parameter int LAT_MIN = 2,
  parameter int LAT_MAX = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic [LAT_W-1:0]  cfg_lat_i,
  input  logic [TURN_W-1:0] cfg_turn_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              wr_ready_o,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              mem_clk_o,
  output logic              mem_ce_no,
  output logic              mem_adv_no,
  output logic              mem_we_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_wdata_oe_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_wait_ni
);

  localparam logic [DIV_W-1:0] DivLo = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] DivHi = DIV_W'(DIV_MAX);
  localparam logic [LAT_W-1:0] LatLo = LAT_W'(LAT_MIN);
  localparam logic [LAT_W-1:0] LatHi = LAT_W'(LAT_MAX);

  logic              accept;
  logic [DIV_W-1:0]  div_sat, ratio_q;
  logic [LAT_W-1:0]  lat_sat, lat_q;
  logic [TURN_W-1:0] turn_q;
  logic              idle, run, run_nxt, rise, fall;
  logic              take, load, wr_dir;

  assign div_sat = (cfg_div_i < DivLo) ? DivLo : (cfg_div_i > DivHi) ? DivHi : cfg_div_i;
  assign lat_sat = (cfg_lat_i < LatLo) ? LatLo : (cfg_lat_i > LatHi) ? LatHi : cfg_lat_i;

  assign req_ready_o = idle;
  assign accept      = req_valid_i && idle;

  // settings frozen for the life of a burst
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= DivLo;
      lat_q   <= LatLo;
      turn_q  <= '0;
    end else if (accept) begin
      ratio_q <= div_sat;
      lat_q   <= lat_sat;
      turn_q  <= cfg_turn_i;
    end
  end

  sbm_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .run_nxt_i (run_nxt),
    .ratio_i   (ratio_q),
    .mem_clk_o (mem_clk_o),
    .rise_o    (rise),
    .fall_o    (fall)
  );

  sbm_seq #(.LEN_W(LEN_W), .LAT_W(LAT_W), .TURN_W(TURN_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .req_write_i (req_write_i),
    .req_len_i   (req_len_i),
    .lat_i       (lat_q),
    .turn_i      (turn_q),
    .rise_i      (rise),
    .fall_i      (fall),
    .wait_ni     (mem_wait_ni),
    .idle_o      (idle),
    .run_o       (run),
    .run_nxt_o   (run_nxt),
    .take_o      (take),
    .load_o      (load),
    .wr_o        (wr_dir),
    .ce_no       (mem_ce_no),
    .adv_no      (mem_adv_no),
    .we_no       (mem_we_no),
    .oe_o        (mem_wdata_oe_o)
  );

  sbm_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .addr_i     (req_addr_i),
    .take_rd_i  (take && !wr_dir),
    .load_i     (load),
    .rdata_i    (mem_rdata_i),
    .wdata_i    (wr_data_i),
    .addr_o     (mem_addr_o),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .wdata_o    (mem_wdata_o)
  );

  assign wr_ready_o = load;

endmodule

// File: rtl/sbm_ctrl_chk.sv
module sbm_ctrl_chk #(
  parameter int ADDR_W = 26
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rd_valid_o,
  input logic              wr_ready_o,
  input logic              mem_clk_o,
  input logic              mem_ce_no,
  input logic              mem_adv_no,
  input logic              mem_we_no,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_wdata_oe_o,
  input logic              mem_wait_ni
);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce_no && !mem_clk_o && mem_adv_no && mem_we_no)); // R1
  AST_CLK_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_clk_o |-> !mem_ce_no); // R8
  AST_ADV_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_adv_no |-> !mem_ce_no); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o)); // R3
  AST_RD_NOT_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(mem_wait_ni)); // R5
  AST_RD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o); // R6
  AST_RD_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (mem_we_no && !mem_ce_no)); // R6
  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |=> !wr_ready_o); // R7
  AST_OE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wdata_oe_o |-> (!mem_we_no && !mem_ce_no)); // R7

endmodule

bind sbm_ctrl sbm_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_ready_o    (req_ready_o),
  .rd_valid_o     (rd_valid_o),
  .wr_ready_o     (wr_ready_o),
  .mem_clk_o      (mem_clk_o),
  .mem_ce_no      (mem_ce_no),
  .mem_adv_no     (mem_adv_no),
  .mem_we_no      (mem_we_no),
  .mem_addr_o     (mem_addr_o),
  .mem_wdata_oe_o (mem_wdata_oe_o),
  .mem_wait_ni    (mem_wait_ni)
);

// File: tb/tb_sbm_ctrl.sv
module tb_sbm_ctrl;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  cfg_div_i = 5'd2;
  logic [4:0]  cfg_lat_i = 5'd2;
  logic [3:0]  cfg_turn_i = 4'd0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [25:0] req_addr_i = '0;
  logic [7:0]  req_len_i = '0;
  logic        rd_valid_o;
  logic [15:0] rd_data_o;
  logic        wr_ready_o;
  logic [15:0] wr_data_i = '0;
  logic        mem_clk_o, mem_ce_no, mem_adv_no, mem_we_no;
  logic [25:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic        mem_wdata_oe_o;
  logic [15:0] mem_rdata_i = '0;
  logic        mem_wait_ni = 1'b1;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  sbm_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_div_i(cfg_div_i), .cfg_lat_i(cfg_lat_i), .cfg_turn_i(cfg_turn_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_len_i(req_len_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .wr_ready_o(wr_ready_o), .wr_data_i(wr_data_i),
    .mem_clk_o(mem_clk_o), .mem_ce_no(mem_ce_no), .mem_adv_no(mem_adv_no),
    .mem_we_no(mem_we_no), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_wdata_oe_o(mem_wdata_oe_o), .mem_rdata_i(mem_rdata_i), .mem_wait_ni(mem_wait_ni)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  task automatic test_reset();
    @(negedge clk_i);
    check(mem_clk_o == 0 && mem_ce_no && mem_adv_no && mem_we_no, "R1",
          "idle memory pins", {mem_clk_o, mem_ce_no, mem_adv_no, mem_we_no}, 4'b0111);
    check(req_ready_o && !rd_valid_o && !wr_ready_o && !mem_wdata_oe_o, "R1",
          "idle client strobes", {req_ready_o, rd_valid_o, wr_ready_o, mem_wdata_oe_o}, 4'b1000);
  endtask

  // one burst; wmask bit d = wait asserted in data cycle d; chg_at = index of a mid-burst cfg change
  task automatic burst(input bit wr, input int div, input int lat, input int turn,
                       input int len, input logic [31:0] wmask, input logic [15:0] base,
                       input logic [25:0] addr, input int chg_at);
    int r, lat_e, lo, n, p, d, b, e_idx, tcount, rdcnt, wrcnt, wcount, first_rd, exp_first, widx;
    int clk_err, adv_err, addr_err, rd_err, wd_err, rdy_err, end_err;
    bit data, wt, acc, ld_seen, exp_rdy, exp_rv;
    r = clampi(div, 2, 16); lat_e = clampi(lat, 2, 17); lo = r / 2;
    b = 0; e_idx = -1; tcount = -1; rdcnt = 0; wrcnt = 0; wcount = 0; first_rd = -1; widx = 0;
    clk_err = 0; adv_err = 0; addr_err = 0; rd_err = 0; wd_err = 0; rdy_err = 0; end_err = 0;
    wt = 0; acc = 0; ld_seen = 0;
    exp_first = -1;
    for (int k = 0; k < 32; k++) if (exp_first < 0 && !wmask[k]) exp_first = (1 + lat_e + k) * r + lo;

    @(negedge clk_i);
    cfg_div_i = 5'(div); cfg_lat_i = 5'(lat); cfg_turn_i = 4'(turn);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = addr; req_len_i = 8'(len);
    wr_data_i = base; mem_wait_ni = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (i > 0) @(negedge clk_i);
      if (ld_seen) begin widx++; wr_data_i = 16'(base + widx); ld_seen = 0; end
      if (i == chg_at) begin cfg_div_i = 5'd7; cfg_lat_i = 5'd9; cfg_turn_i = 4'd1; end
      if (e_idx < 0) begin
        n = i / r; p = i % r; data = (n > lat_e); d = n - 1 - lat_e;
        if (p == 0) begin
          acc = 0;
          wt = data && d < 32 && wmask[d];
          mem_wait_ni = !wt;
          mem_rdata_i = data ? 16'(base + b) : 16'(16'hE000 + n);
          if (wt) wcount++;
        end
        if (mem_clk_o != (p >= lo) || mem_ce_no) clk_err++;
        if (mem_adv_no != (n != 0)) adv_err++;
        if (mem_addr_o != addr || mem_we_no != !wr) addr_err++;
        exp_rv = !wr && data && p == lo && !wt;
        if (rd_valid_o != exp_rv) rd_err++;
        if (rd_valid_o && first_rd < 0) first_rd = i;
        if (rd_valid_o) rdcnt++;
        if (p == lo && data && !wt) begin
          if (!wr && rd_data_o != 16'(base + b)) rd_err++;
          if (wr && (mem_wdata_o != 16'(base + b) || !mem_wdata_oe_o)) wd_err++;
          acc = 1; b++;
        end
        exp_rdy = wr && p == r - 1 && (n == lat_e || (data && acc && b <= len));
        if (wr_ready_o != exp_rdy) rdy_err++;
        if (wr_ready_o) begin wrcnt++; ld_seen = 1; end
        if (p == r - 1 && data && acc && b > len) e_idx = i + 1;
      end else begin
        if (!mem_ce_no || mem_clk_o || !mem_we_no || mem_wdata_oe_o) end_err++;
        if (req_ready_o) begin tcount = i - e_idx; break; end
      end
    end
    mem_wait_ni = 1'b1;
    check(clk_err == 0, "R2", "memory clock shape errors", clk_err, 0);
    check(adv_err == 0 && addr_err == 0, "R3", "adv/address/we errors", adv_err + addr_err, 0);
    if (!wr) begin
      check(first_rd == exp_first, "R4", "first read beat cycle", first_rd, exp_first);
      check(rd_err == 0 && rdcnt == len + 1, "R6", "read beats", rdcnt, len + 1);
    end else begin
      check(rdy_err == 0 && wrcnt == len + 1, "R7", "write ready pulses", wrcnt, len + 1);
      check(wd_err == 0, "R7", "write word errors", wd_err, 0);
    end
    check(e_idx == (2 + lat_e + len + wcount) * r, "R5", "burst end cycle with stalls",
          e_idx, (2 + lat_e + len + wcount) * r);
    check(end_err == 0 && tcount == turn, "R8", "turnaround cycles", tcount, turn);
    if (chg_at >= 0)
      check(clk_err == 0 && tcount == turn && e_idx == (2 + lat_e + len + wcount) * r,
            "R9", "settings held through burst", clk_err, 0);
  endtask

  task automatic test_read_basic();   burst(0, 2, 2, 0, 3, 32'h0, 16'h1000, 26'h0000123, -1); endtask
  task automatic test_read_odd_wait(); burst(0, 3, 5, 3, 7, 32'h26, 16'h2200, 26'h2ABCDEF, -1); endtask
  task automatic test_write_wait();   burst(1, 4, 3, 15, 4, 32'h9, 16'h3300, 26'h1000001, -1); endtask
  task automatic test_low_clamp();    burst(0, 1, 0, 2, 0, 32'h1, 16'h4400, 26'h0000004, -1); endtask
  task automatic test_write_hi_chg(); burst(1, 20, 31, 4, 1, 32'h0, 16'h5500, 26'h3FFFFFF, 40); endtask
  task automatic test_read_chg();     burst(0, 5, 17, 6, 2, 32'h2, 16'h6600, 26'h0155555, 12); endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset();
    test_read_basic();
    test_read_odd_wait();
    test_write_wait();
    test_low_clamp();
    test_write_hi_chg();
    test_read_chg();
    test_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule